// File: doc/BRIEF.md
# Multi-Core Hardware Semaphore Bank

The block holds a bank of hardware semaphores that several processor cores share to guard common resources. Each semaphore remembers whether it is taken, which core took it and a process number chosen by the taker. A core claims a semaphore in one of two ways. It can write a claim and then read the register back to see whether it now owns it. It can also read a claim alias, which takes a free semaphore in the same access and returns the result. A release is accepted only from the current owner. A key-guarded command frees every semaphore one core holds at once.

Every release marks a per-semaphore status bit in each core's own status set. Each core has its own enable mask and write-one-to-clear register, and its interrupt line follows those bits. The bank has several request ports. Each request carries the core ID of the requesting master. Requests that arrive in the same cycle are applied in port order, so a free semaphore has exactly one winner.

Top module: `hwsem_bank`

## Requirements
- R1: After reset every semaphore is free with owner core 0 and process 0. The key, all enable bits and all status bits are 0, and both interrupt lines are low.
- R2: Word layout of a semaphore: bit 31 is taken, bits [11:8] are the owner core and bits [7:0] are the process. A write to address x (0 to 31) with bit 31 set, bits [11:8] equal to the requester's core ID and process P takes a free semaphore. A later read of x then returns {1, core, P}.
- R3: A claim on a semaphore held by any owner leaves it unchanged, and a read shows the real holder. A write to address x whose bits [11:8] differ from the requester's core ID has no effect.
- R4: A read of address 32+x on a free semaphore takes it for the reading core with process 0 and returns {1, core, 0}. On a held semaphore the read returns the holder and changes nothing.
- R5: A write to address x with bit 31 clear frees the semaphore only when the written core and process equal the stored owner. A freed semaphore reads as 0.
- R6: A write to address 0x40 carries a key in bits [31:16] and a core in bits [11:8]. When the key equals the stored key, it frees every semaphore held by that core. Otherwise it does nothing.
- R7: The key is held in bits [15:0] of address 0x41, can be read and written, and resets to 0.
- R8: Core c has its enable register at 0x44+4c (read/write), its status register at 0x45+4c (read) and its clear register at 0x46+4c (write 1 to clear). Each freed semaphore sets its status bit for every core.
- R9: Interrupt line c is high when status and enable of core c share a set bit. If a clear and a release of the same semaphore fall in the same cycle, the status bit ends up set.
- R10: Requests in one cycle are applied in port order, port 0 first. A later port sees the effects of earlier ports, so only one port can take a given free semaphore.
- R11: Read data for a request appears on that port's response the cycle after the request. It is 0 in a cycle after no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NPORT | Request present, one bit per port |
| req_write | input | NPORT | 1 = write, 0 = read |
| req_addr | input | NPORT x AW | Word address per port |
| req_wdata | input | NPORT x 32 | Write data per port |
| req_core | input | NPORT x CW | Core ID of the requesting master |
| rsp_rdata | output | NPORT x 32 | Read data, one cycle after the request |
| irq | output | NCORE | Release interrupt per core |

## Verification
An owner that is stored wrongly shows up at the very next read of the lock or claim alias as the wrong core or process field. It also shows up as a release that is refused or granted for the wrong requester. A lost or extra release shows in the status registers and on the interrupt lines in the cycle right after the access. A port-order error shows in the same-cycle port 1 response. The directed cases place every such access so that the fault becomes visible within one or two cycles.

// File: rtl/hwsem_bank.sv
module hwsem_bank #(
  parameter int NSEM  = 32,
  parameter int NPORT = 2,
  parameter int NCORE = 2,
  parameter int CW    = 4,
  parameter int PW    = 8,
  parameter int AW    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NPORT-1:0]             req_valid,
  input  logic [NPORT-1:0]             req_write,
  input  logic [NPORT-1:0][AW-1:0]     req_addr,
  input  logic [NPORT-1:0][31:0]       req_wdata,
  input  logic [NPORT-1:0][CW-1:0]     req_core,
  output logic [NPORT-1:0][31:0]       rsp_rdata,
  output logic [NCORE-1:0]             irq
);
  localparam int SIW = $clog2(NSEM);
  localparam int PAD = 31 - PW - CW;
  localparam logic [AW-1:0] A_ALIAS = AW'(NSEM);
  localparam logic [AW-1:0] A_BULK  = AW'(2 * NSEM);
  localparam logic [AW-1:0] A_KEY   = AW'(2 * NSEM + 1);
  localparam int A_CORE = 2 * NSEM + 4;

  logic [NSEM-1:0]                lk, n_lk;
  logic [NSEM-1:0][CW-1:0]        oc, n_oc;
  logic [NSEM-1:0][PW-1:0]        op, n_op;
  logic [15:0]                    key, n_key;
  logic [NCORE-1:0][NSEM-1:0]     ier, n_ier, isr, clr;
  logic [NSEM-1:0]                rel;
  logic [NPORT-1:0][31:0]         rd;

  function automatic logic [31:0] pack(input logic l, input logic [CW-1:0] c,
                                       input logic [PW-1:0] q);
    return {l, {PAD{1'b0}}, c, q};
  endfunction

  always_comb begin
    logic [AW-1:0]   a;
    logic [31:0]     d;
    logic [CW-1:0]   c;
    logic [SIW-1:0]  ix;
    n_lk = lk; n_oc = oc; n_op = op; n_key = key; n_ier = ier;
    rel = '0; clr = '0; rd = '0;
    for (int p = 0; p < NPORT; p++) begin
      a  = req_addr[p];
      d  = req_wdata[p];
      c  = req_core[p];
      ix = a[SIW-1:0];
      if (req_valid[p]) begin
        if (a < A_ALIAS) begin
          if (req_write[p]) begin
            if (d[PW+CW-1:PW] == c) begin
              if (d[31]) begin
                if (!n_lk[ix]) begin
                  n_lk[ix] = 1'b1; n_oc[ix] = c; n_op[ix] = d[PW-1:0];
                end
              end else if (n_lk[ix] && n_oc[ix] == c && n_op[ix] == d[PW-1:0]) begin
                n_lk[ix] = 1'b0; n_oc[ix] = '0; n_op[ix] = '0; rel[ix] = 1'b1;
              end
            end
          end else begin
            rd[p] = pack(n_lk[ix], n_oc[ix], n_op[ix]);
          end
        end else if (a < A_BULK) begin
          if (!req_write[p]) begin
            if (!n_lk[ix]) begin
              n_lk[ix] = 1'b1; n_oc[ix] = c; n_op[ix] = '0;
            end
            rd[p] = pack(n_lk[ix], n_oc[ix], n_op[ix]);
          end
        end else if (a == A_BULK) begin
          if (req_write[p] && d[31:16] == n_key) begin
            for (int s = 0; s < NSEM; s++) begin
              if (n_lk[s] && n_oc[s] == d[PW+CW-1:PW]) begin
                n_lk[s] = 1'b0; n_oc[s] = '0; n_op[s] = '0; rel[s] = 1'b1;
              end
            end
          end
        end else if (a == A_KEY) begin
          if (req_write[p]) n_key = d[15:0];
          else rd[p] = {16'h0, n_key};
        end else begin
          for (int k = 0; k < NCORE; k++) begin
            if (a == AW'(A_CORE + 4 * k)) begin
              if (req_write[p]) n_ier[k] = d[NSEM-1:0];
              else rd[p] = 32'(n_ier[k]);
            end
            if (a == AW'(A_CORE + 4 * k + 1) && !req_write[p]) rd[p] = 32'(isr[k]);
            if (a == AW'(A_CORE + 4 * k + 2) && req_write[p]) clr[k] = clr[k] | d[NSEM-1:0];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk <= '0; oc <= '0; op <= '0; key <= '0;
      ier <= '0; isr <= '0; rsp_rdata <= '0;
    end else begin
      lk <= n_lk; oc <= n_oc; op <= n_op; key <= n_key;
      ier <= n_ier; rsp_rdata <= rd;
      for (int k = 0; k < NCORE; k++) isr[k] <= (isr[k] & ~clr[k]) | rel;
    end
  end

  for (genvar g = 0; g < NCORE; g++) begin : g_irq
    assign irq[g] = |(isr[g] & ier[g]);
  end
endmodule

// File: rtl/hwsem_bank_chk.sv
module hwsem_bank_chk #(
  parameter int NSEM  = 32,
  parameter int NPORT = 2,
  parameter int NCORE = 2,
  parameter int CW    = 4,
  parameter int PW    = 8,
  parameter int AW    = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NSEM-1:0]          lk,
  input logic [NSEM-1:0][CW-1:0]  oc,
  input logic [NSEM-1:0][PW-1:0]  op,
  input logic [NCORE-1:0][NSEM-1:0] isr,
  input logic [NCORE-1:0][NSEM-1:0] ier,
  input logic [NCORE-1:0]         irq,
  input logic [NPORT-1:0]         req_valid,
  input logic [NPORT-1:0]         req_write,
  input logic [NPORT-1:0][AW-1:0] req_addr,
  input logic [NPORT-1:0][31:0]   rsp_rdata
);
  localparam logic [AW-1:0] A_ALIAS = AW'(NSEM);
  localparam logic [AW-1:0] A_BULK  = AW'(2 * NSEM);

  logic unused_rsp_bits;
  assign unused_rsp_bits = ^rsp_rdata;

  for (genvar s = 0; s < NSEM; s++) begin : g_sem
    assert_free_has_no_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !lk[s] |-> (oc[s] == '0 && op[s] == '0));
    for (genvar k = 0; k < NCORE; k++) begin : g_core
      assert_release_sets_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lk[s]) |-> isr[k][s]);
    end
  end

  for (genvar k = 0; k < NCORE; k++) begin : g_irq
    assert_irq_quiet_when_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ier[k] == '0) |-> !irq[k]);
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assert_alias_read_returns_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(req_valid[p]) && !$past(req_write[p]) &&
       $past(req_addr[p]) >= A_ALIAS && $past(req_addr[p]) < A_BULK) |-> rsp_rdata[p][31]);
  end
endmodule

bind hwsem_bank hwsem_bank_chk #(.NSEM(NSEM), .NPORT(NPORT), .NCORE(NCORE), .CW(CW),
                                 .PW(PW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk(lk), .oc(oc), .op(op), .isr(isr), .ier(ier),
  .irq(irq), .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
  .rsp_rdata(rsp_rdata)
);

// File: tb/sim_hwsem_bank.sv
module sim_hwsem_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] v = '0, w = '0;
  logic [1:0][7:0]  ad = '0;
  logic [1:0][31:0] wd = '0;
  logic [1:0][3:0]  cr = '0;
  logic [1:0][31:0] rd;
  logic [1:0]       irq;
  int tests = 0, fails = 0;
  logic [31:0] r, r1;

  always #10 clk = ~clk;

  hwsem_bank u0 (.clk(clk), .rst_n(rst_n), .req_valid(v), .req_write(w), .req_addr(ad),
                 .req_wdata(wd), .req_core(cr), .rsp_rdata(rd), .irq(irq));

  function automatic logic [31:0] lw(input logic l, input logic [3:0] c, input logic [7:0] q);
    return {l, 19'h0, c, q};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic op(input int p, input logic we, input logic [7:0] a, input logic [31:0] d,
                    input logic [3:0] c, output logic [31:0] res);
    v[p] = 1'b1; w[p] = we; ad[p] = a; wd[p] = d; cr[p] = c;
    @(negedge clk);
    v[p] = 1'b0;
    res = rd[p];
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] c);
    logic [31:0] dummy;
    op(0, 1'b1, a, d, c, dummy);
  endtask

  task automatic rdr(input logic [7:0] a, input logic [3:0] c, output logic [31:0] res);
    op(0, 1'b0, a, 32'h0, c, res);
  endtask

  task automatic dual(input logic we0, input logic [7:0] a0, input logic [31:0] d0, input logic [3:0] c0,
                      input logic we1, input logic [7:0] a1, input logic [31:0] d1, input logic [3:0] c1,
                      output logic [31:0] q0, output logic [31:0] q1);
    v = 2'b11; w = {we1, we0}; ad = {a1, a0}; wd = {d1, d0}; cr = {c1, c0};
    @(negedge clk);
    v = 2'b00;
    q0 = rd[0]; q1 = rd[1];
  endtask

  task automatic t_reset;
    logic [31:0] q;
    check("R1 irq after reset", 32'(irq), 32'h0);
    rdr(8'd5, 4'd3, q);      check("R1 sem5 free", q, 32'h0);
    rdr(8'h41, 4'd3, q);     check("R7 key resets to 0", q, 32'h0);
    rdr(8'h45, 4'd3, q);     check("R1 status core0", q, 32'h0);
  endtask

  task automatic t_two_step;
    logic [31:0] q;
    wr(8'd2, lw(1, 4'd3, 8'h12), 4'd3);
    rdr(8'd2, 4'd3, q);      check("R2 two-step claim", q, lw(1, 4'd3, 8'h12));
    @(negedge clk);
    check("R11 idle response zero", rd[0], 32'h0);
  endtask

  task automatic t_contest;
    logic [31:0] q;
    wr(8'd2, lw(1, 4'd1, 8'h55), 4'd1);
    rdr(8'd2, 4'd1, q);      check("R3 claim on held sem", q, lw(1, 4'd3, 8'h12));
    wr(8'd2, lw(0, 4'd3, 8'h12), 4'd1);
    rdr(8'd2, 4'd1, q);      check("R3 forged core field ignored", q, lw(1, 4'd3, 8'h12));
  endtask

  task automatic t_unlock;
    logic [31:0] q;
    wr(8'd2, lw(0, 4'd3, 8'h13), 4'd3);
    rdr(8'd2, 4'd3, q);      check("R5 wrong process keeps lock", q, lw(1, 4'd3, 8'h12));
    wr(8'd2, lw(0, 4'd3, 8'h12), 4'd3);
    rdr(8'd2, 4'd3, q);      check("R5 owner release", q, 32'h0);
    rdr(8'h45, 4'd3, q);     check("R8 status core0", q, 32'h4);
    rdr(8'h49, 4'd3, q);     check("R8 status core1", q, 32'h4);
  endtask

  task automatic t_one_step;
    logic [31:0] q;
    rdr(8'h27, 4'd4, q);     check("R4 alias takes free sem", q, lw(1, 4'd4, 8'h0));
    rdr(8'h27, 4'd8, q);     check("R4 alias on held sem", q, lw(1, 4'd4, 8'h0));
    rdr(8'd7, 4'd8, q);      check("R4 owner kept", q, lw(1, 4'd4, 8'h0));
  endtask

  task automatic t_irq;
    logic [31:0] q;
    wr(8'h48, 32'h80, 4'd1);
    rdr(8'h48, 4'd1, q);     check("R8 enable readback", q, 32'h80);
    check("R9 irq low before release", 32'(irq), 32'h0);
    wr(8'd7, lw(0, 4'd4, 8'h0), 4'd4);
    check("R9 irq raised for enabled core only", 32'(irq), 32'h2);
    wr(8'h4A, 32'h80, 4'd1);
    check("R9 irq dropped after clear", 32'(irq), 32'h0);
    rdr(8'h49, 4'd1, q);     check("R8 clear removes one bit", q, 32'h4);
  endtask

  task automatic t_race;
    logic [31:0] q0, q1, q;
    wr(8'd9, lw(1, 4'd1, 8'h1), 4'd1);
    dual(1'b1, 8'd9, lw(0, 4'd1, 8'h1), 4'd1, 1'b1, 8'h4A, 32'h200, 4'd1, q0, q1);
    rdr(8'h49, 4'd1, q);     check("R9 release beats clear", q, 32'h204);
  endtask

  task automatic t_bulk;
    logic [31:0] q;
    wr(8'h41, 32'hBEEF, 4'd3);
    rdr(8'h41, 4'd3, q);     check("R7 key readback", q, 32'hBEEF);
    wr(8'd10, lw(1, 4'd3, 8'h1), 4'd3);
    wr(8'd11, lw(1, 4'd3, 8'h2), 4'd3);
    wr(8'd12, lw(1, 4'd1, 8'h5), 4'd1);
    wr(8'h40, {16'hBEEE, 4'h0, 4'h3, 8'h0}, 4'd3);
    rdr(8'd10, 4'd3, q);     check("R6 wrong key ignored", q, lw(1, 4'd3, 8'h1));
    wr(8'h40, {16'hBEEF, 4'h0, 4'h3, 8'h0}, 4'd3);
    rdr(8'd10, 4'd3, q);     check("R6 bulk frees sem10", q, 32'h0);
    rdr(8'd11, 4'd3, q);     check("R6 bulk frees sem11", q, 32'h0);
    rdr(8'd12, 4'd3, q);     check("R6 other core kept", q, lw(1, 4'd1, 8'h5));
    rdr(8'h45, 4'd3, q);     check("R8 status after bulk", q, 32'hE84);
  endtask

  task automatic t_order;
    logic [31:0] q0, q1;
    dual(1'b0, 8'h34, 32'h0, 4'd3, 1'b0, 8'h34, 32'h0, 4'd8, q0, q1);
    check("R10 port0 wins alias", q0, lw(1, 4'd3, 8'h0));
    check("R10 port1 sees port0 owner", q1, lw(1, 4'd3, 8'h0));
    dual(1'b1, 8'd21, lw(1, 4'd1, 8'h7), 4'd1, 1'b0, 8'd21, 32'h0, 4'd8, q0, q1);
    check("R10 port1 read after port0 claim", q1, lw(1, 4'd1, 8'h7));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_two_step;
    t_contest;
    t_unlock;
    t_one_step;
    t_irq;
    t_race;
    t_bulk;
    t_order;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule